// File: doc/BRIEF.md
# Tiered Row-Hit-First Request Picker

This block chooses which pending request one memory channel services next. Requests arrive one per cycle. Each names a bank, a row, a direction (read or write) and a single priority bit that marks it as coming from a light, low-intensity application. The block keeps them in a fixed pool of slots and stamps each with an arrival number. In every cycle that the channel says it can issue, the block names one slot as the grant. The grant leaves the pool at the next clock edge. The granted row becomes the open row of its bank.

The ordering has four levels. Low-intensity requests come first. Among those of equal tier, reads come before writes. Next, a request that hits the open row of its bank beats a miss. The last tie goes to the oldest arrival. The arrival stamp is a wrapping counter, so ages are compared by modular difference. No application identifier is carried and no ranking is kept. DRAM timing and command generation are left to the logic around the block.

Top module: `row_hit_sched`

## Requirements
- R1: A valid request with `enq_low`=1 (low-intensity tier) is always granted before any request with `enq_low`=0, whatever its direction, row-hit status or age.
- R2: Within one tier, a read (`enq_write`=0) is granted before a write (`enq_write`=1), even when the write hits its open row and the read misses.
- R3: Within one tier and direction, a request whose row equals the open row of its bank is granted before a request that misses.
- R4: Requests that tie on tier, direction and hit status are granted oldest first. Age comes from a 16-bit arrival stamp that advances by one per accepted request, and two stamps are compared by the sign of their modular difference, so stamp 0xFFFF is older than stamp 0x0000.
- R5: On a grant, `grant_bank` and `grant_row` give the bank and row of the granted slot. From the next cycle that row is the open row of that bank, whether the grant was a hit or a miss.
- R6: After reset the pool is empty, `enq_ready` is 1, and every bank has no open row, so the first request to any bank (including row 0) counts as a miss.
- R7: `grant_valid` is 1 exactly when `issue_ready` is 1 and the pool holds at least one request. `grant_idx` is valid in the same cycle, and the granted slot is empty from the next cycle on. With `issue_ready` at 0, requests stay pending.
- R8: An accepted request is written into the lowest-numbered empty slot, and that slot number is the one later reported on `grant_idx`. When all DEPTH slots (128) are occupied, `enq_ready` is 0 and a request offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | A new request is offered this cycle |
| enq_bank | input | 3 | Bank of the offered request |
| enq_row | input | 14 | Row of the offered request |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_low | input | 1 | 1 = low-intensity tier |
| enq_ready | output | 1 | 1 when a free slot exists; the offer is accepted when this and enq_valid are both 1 |
| issue_ready | input | 1 | Channel can take one request this cycle |
| grant_valid | output | 1 | A slot is granted this cycle |
| grant_idx | output | 7 | Slot number of the granted request |
| grant_bank | output | 3 | Bank of the granted request |
| grant_row | output | 14 | Row of the granted request, the bank's new open row |

## Verification
The bench builds cases in which each ordering level overrules the levels below it. A low-intensity write beats a normal read that hits. A read that misses beats a write that hits. A younger hit beats an older miss. If two levels were swapped, or the direction level were dropped, the wrong slot index would be granted.

Further cases cover three more faults. With reset banks treated as open on row 0, a younger row-0 request would be granted first. Without a miss updating the open row, a later hit would lose to an older request. Without wraparound in the age compare, the request stamped 0x0000 would beat the one stamped 0xFFFF. A full pool that accepted a further offer, or that lost an entry, shows up as a wrong grant count when the pool is drained.

// File: rtl/sched_pkg.sv
package sched_pkg;

    parameter int DEPTH   = 128;
    parameter int BANKS   = 8;
    parameter int ROW_W   = 14;
    parameter int STAMP_W = 16;

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int BANK_W = $clog2(BANKS);
    localparam int LEVELS = $clog2(DEPTH);

    // One stored request
    typedef struct packed {
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [STAMP_W-1:0] stamp;
        logic               wr;
        logic               low;
    } entry_t;

    // Candidate travelling up the selection tree.
    // key = {low tier, is read, row hit}; larger wins.
    typedef struct packed {
        logic               vld;
        logic [2:0]         key;
        logic [STAMP_W-1:0] stamp;
        logic [IDX_W-1:0]   idx;
    } cand_t;

    // True when stamp a was issued before stamp b (modular compare)
    function automatic logic stamp_older(input logic [STAMP_W-1:0] a,
                                         input logic [STAMP_W-1:0] b);
        logic [STAMP_W-1:0] d;
        d = a - b;
        return d[STAMP_W-1];
    endfunction

    // Pick the better of two candidates; a holds the lower slot numbers
    function automatic cand_t pick2(input cand_t a, input cand_t b);
        if (!b.vld)              return a;
        if (!a.vld)              return b;
        if (a.key != b.key)      return (a.key > b.key) ? a : b;
        if (stamp_older(b.stamp, a.stamp)) return b;
        return a;
    endfunction

endpackage

// File: rtl/sched_queue.sv
module sched_queue
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic              enq_write,
    input  logic              enq_low,
    output logic              enq_ready,
    input  logic              rm_valid,
    input  logic [IDX_W-1:0]  rm_idx,
    output logic [DEPTH-1:0]  vld,
    output entry_t            ents [DEPTH]
);

    logic [STAMP_W-1:0] stamp_q;
    logic [IDX_W-1:0]   free_idx;
    logic               full;
    logic               take;

    assign full      = &vld;
    assign enq_ready = !full;
    assign take      = enq_valid && !full;

    // Lowest-numbered empty slot
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= '0;
            stamp_q <= '0;
        end else begin
            if (rm_valid) vld[rm_idx] <= 1'b0;
            if (take) begin
                vld[free_idx] <= 1'b1;
                stamp_q       <= stamp_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            ents[free_idx] <= '{bank: enq_bank, row: enq_row, stamp: stamp_q,
                                wr: enq_write, low: enq_low};
        end
    end

endmodule

// File: rtl/bank_rows.sv
module bank_rows
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    output logic [BANKS-1:0]  open_vld,
    output logic [ROW_W-1:0]  open_row [BANKS]
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_vld[b] <= 1'b0;
                open_row[b] <= '0;
            end else if (upd && upd_bank == BANK_W'(b)) begin
                open_vld[b] <= 1'b1;
                open_row[b] <= upd_row;
            end
        end
    end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
    import sched_pkg::*;
(
    input  logic [DEPTH-1:0] vld,
    input  entry_t           ents [DEPTH],
    input  logic [BANKS-1:0] open_vld,
    input  logic [ROW_W-1:0] open_row [BANKS],
    output cand_t            best
);

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lv
        localparam int W = DEPTH >> lv;
        cand_t c [W];
        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_i
                logic hit;
                assign hit = open_vld[ents[i].bank] &&
                             (open_row[ents[i].bank] == ents[i].row);
                assign c[i] = '{vld:   vld[i],
                                key:   {ents[i].low, !ents[i].wr, hit},
                                stamp: ents[i].stamp,
                                idx:   IDX_W'(i)};
            end
        end else begin : g_node
            for (genvar i = 0; i < W; i++) begin : g_i
                assign c[i] = pick2(g_lv[lv-1].c[2*i], g_lv[lv-1].c[2*i+1]);
            end
        end
    end

    assign best = g_lv[LEVELS].c[0];

endmodule

// File: rtl/row_hit_sched.sv
module row_hit_sched
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic              enq_write,
    input  logic              enq_low,
    output logic              enq_ready,
    input  logic              issue_ready,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_idx,
    output logic [BANK_W-1:0] grant_bank,
    output logic [ROW_W-1:0]  grant_row
);

    logic [DEPTH-1:0] vld;
    entry_t           ents [DEPTH];
    logic [BANKS-1:0] open_vld;
    logic [ROW_W-1:0] open_row [BANKS];
    cand_t            best;
    logic [DEPTH-1:0] ent_low;
    logic [DEPTH-1:0] ent_wr;
    logic             enq_fire;

    sched_queue u_queue (
        .clk       (clk),
        .rst       (rst),
        .enq_valid (enq_valid),
        .enq_bank  (enq_bank),
        .enq_row   (enq_row),
        .enq_write (enq_write),
        .enq_low   (enq_low),
        .enq_ready (enq_ready),
        .rm_valid  (grant_valid),
        .rm_idx    (grant_idx),
        .vld       (vld),
        .ents      (ents)
    );

    sched_pick u_pick (
        .vld      (vld),
        .ents     (ents),
        .open_vld (open_vld),
        .open_row (open_row),
        .best     (best)
    );

    bank_rows u_rows (
        .clk      (clk),
        .rst      (rst),
        .upd      (grant_valid),
        .upd_bank (grant_bank),
        .upd_row  (grant_row),
        .open_vld (open_vld),
        .open_row (open_row)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_flag
        assign ent_low[i] = ents[i].low;
        assign ent_wr[i]  = ents[i].wr;
    end

    assign enq_fire    = enq_valid && enq_ready;
    assign grant_valid = issue_ready && best.vld;
    assign grant_idx   = best.idx;
    assign grant_bank  = ents[best.idx].bank;
    assign grant_row   = ents[best.idx].row;

endmodule

// File: rtl/sched_checker.sv
module sched_checker
    import sched_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DEPTH-1:0]  vld,
    input logic [DEPTH-1:0]  ent_low,
    input logic [DEPTH-1:0]  ent_wr,
    input logic              enq_fire,
    input logic              issue_ready,
    input logic              grant_valid,
    input logic [IDX_W-1:0]  grant_idx,
    input logic [BANK_W-1:0] grant_bank,
    input logic [ROW_W-1:0]  grant_row,
    input logic [BANKS-1:0]  open_vld,
    input logic [ROW_W-1:0]  open_row [BANKS]
);

    int occ;
    assign occ = $countones(vld);

    assert_no_grant_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !issue_ready |-> !grant_valid);

    assert_grant_live_R7: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> vld[grant_idx]);

    assert_grant_removed_R7: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> !vld[$past(grant_idx)]);

    assert_occupancy_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> occ == $past(occ) + ($past(enq_fire) ? 1 : 0)
                                   - ($past(grant_valid) ? 1 : 0));

    assert_open_row_R5: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> open_vld[$past(grant_bank)] &&
                        open_row[$past(grant_bank)] == $past(grant_row));

    assert_low_tier_R1: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && |(vld & ent_low)) |-> ent_low[grant_idx]);

    assert_read_first_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !ent_low[grant_idx] && ent_wr[grant_idx])
            |-> !(|(vld & ~ent_wr)));

endmodule

bind row_hit_sched sched_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .vld         (vld),
    .ent_low     (ent_low),
    .ent_wr      (ent_wr),
    .enq_fire    (enq_fire),
    .issue_ready (issue_ready),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_bank  (grant_bank),
    .grant_row   (grant_row),
    .open_vld    (open_vld),
    .open_row    (open_row)
);

// File: tb/tb_row_hit_sched.sv
`timescale 1ns/1ps
module tb_row_hit_sched;

    logic        clk = 1'b0;
    logic        rst;
    logic        enq_valid = 1'b0;
    logic [2:0]  enq_bank = '0;
    logic [13:0] enq_row = '0;
    logic        enq_write = 1'b0;
    logic        enq_low = 1'b0;
    logic        enq_ready;
    logic        issue_ready = 1'b0;
    logic        grant_valid;
    logic [6:0]  grant_idx;
    logic [2:0]  grant_bank;
    logic [13:0] grant_row;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic [15:0] stamp_ctr = '0;

    // bench-side model of slot occupancy (R8: lowest free slot)
    logic        m_vld  [128];
    logic [2:0]  m_bank [128];
    logic [13:0] m_row  [128];

    always #2.5 clk = ~clk;

    row_hit_sched dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_bank(enq_bank), .enq_row(enq_row),
        .enq_write(enq_write), .enq_low(enq_low), .enq_ready(enq_ready),
        .issue_ready(issue_ready), .grant_valid(grant_valid),
        .grant_idx(grant_idx), .grant_bank(grant_bank), .grant_row(grant_row)
    );

    typedef struct packed {
        logic       op;    // 0 = enqueue, 1 = issue and check
        logic [2:0] bank;
        logic [7:0] row;
        logic       wr;
        logic       low;
        logic [6:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        // R6: closed banks after reset, so row 0 misses; R4 oldest first
        '{1'b0, 3'd0, 8'd5, 1'b0, 1'b0, 7'd0, 4'd6},
        '{1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd6},
        '{1'b0, 3'd1, 8'd6, 1'b0, 1'b0, 7'd0, 4'd6},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd6},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd1, 4'd4},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd2, 4'd4},
        // R3: younger hit beats older miss
        '{1'b0, 3'd0, 8'd9, 1'b0, 1'b0, 7'd0, 4'd3},
        '{1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd3},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd1, 4'd3},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd3},
        // R1: low-tier miss beats normal hit
        '{1'b0, 3'd1, 8'd6, 1'b0, 1'b0, 7'd0, 4'd1},
        '{1'b0, 3'd2, 8'd3, 1'b0, 1'b1, 7'd0, 4'd1},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd1, 4'd1},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd1},
        // R2: read miss beats write hit
        '{1'b0, 3'd1, 8'd6, 1'b1, 1'b0, 7'd0, 4'd2},
        '{1'b0, 3'd3, 8'd1, 1'b0, 1'b0, 7'd0, 4'd2},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd1, 4'd2},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd2},
        // R5: a miss grant opens row 7 in bank 0, later hit on 7 wins
        '{1'b0, 3'd0, 8'd7, 1'b0, 1'b0, 7'd0, 4'd5},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd5},
        '{1'b0, 3'd0, 8'd9, 1'b0, 1'b0, 7'd0, 4'd5},
        '{1'b0, 3'd0, 8'd7, 1'b0, 1'b0, 7'd0, 4'd5},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd1, 4'd5},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd5},
        // R1: low-tier write beats normal read hit
        '{1'b0, 3'd0, 8'd9, 1'b0, 1'b0, 7'd0, 4'd1},
        '{1'b0, 3'd4, 8'd2, 1'b1, 1'b1, 7'd0, 4'd1},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd1, 4'd1},
        '{1'b1, 3'd0, 8'd0, 1'b0, 1'b0, 7'd0, 4'd1}
    };

    task automatic chk(input logic ok, input string rq,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic enq(input logic [2:0] b, input logic [13:0] r,
                       input logic w, input logic l);
        logic acc;
        @(negedge clk);
        enq_valid = 1'b1; enq_bank = b; enq_row = r;
        enq_write = w; enq_low = l; issue_ready = 1'b0;
        #1;
        acc = enq_ready;
        @(posedge clk);
        #1;
        enq_valid = 1'b0;
        if (acc) begin
            stamp_ctr = stamp_ctr + 1'b1;
            for (int i = 0; i < 128; i++) begin
                if (!m_vld[i]) begin
                    m_vld[i] = 1'b1; m_bank[i] = b; m_row[i] = r;
                    break;
                end
            end
        end
    endtask

    task automatic issue(input int exp, input string rq);
        @(negedge clk);
        issue_ready = 1'b1;
        #1;
        chk(grant_valid === 1'b1, rq, int'(grant_valid), 1);
        chk(grant_idx === 7'(exp), rq, int'(grant_idx), exp);
        chk(grant_bank === m_bank[exp] && grant_row === m_row[exp], "R5",
            int'(grant_row), int'(m_row[exp]));
        @(posedge clk);
        #1;
        issue_ready = 1'b0;
        m_vld[exp] = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        logic bad;
        for (int i = 0; i < 128; i++) m_vld[i] = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R6: empty pool, ready for requests, no grant
        @(negedge clk);
        issue_ready = 1'b1;
        #1;
        chk(enq_ready === 1'b1, "R6", int'(enq_ready), 1);
        chk(grant_valid === 1'b0, "R6", int'(grant_valid), 0);
        issue_ready = 1'b0;

        // Table of ordering scenarios
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].op == 1'b0)
                enq(VECS[v].bank, 14'(VECS[v].row), VECS[v].wr, VECS[v].low);
            else
                issue(int'(VECS[v].exp), $sformatf("R%0d", VECS[v].rq));
        end

        // R7: request waits while issue_ready is low
        enq(3'd2, 14'd3, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(grant_valid === 1'b0, "R7", int'(grant_valid), 0);
        end
        issue(0, "R7");
        @(negedge clk);
        issue_ready = 1'b1;
        #1;
        chk(grant_valid === 1'b0, "R7", int'(grant_valid), 0);
        issue_ready = 1'b0;

        // R8: fill all slots, then offer one more (low tier, bank 5)
        for (int k = 0; k < 128; k++) enq(3'd7, 14'd1, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        chk(enq_ready === 1'b0, "R8", int'(enq_ready), 0);
        enq(3'd5, 14'd2, 1'b0, 1'b1);
        n = 0;
        bad = 1'b0;
        for (int k = 0; k < 140; k++) begin
            @(negedge clk);
            issue_ready = 1'b1;
            #1;
            if (grant_valid) begin
                n++;
                if (grant_bank == 3'd5) bad = 1'b1;
            end
        end
        issue_ready = 1'b0;
        for (int i = 0; i < 128; i++) m_vld[i] = 1'b0;
        chk(n == 128, "R8", n, 128);
        chk(bad == 1'b0, "R8", int'(bad), 0);

        // R4: advance the stamp to 0xFFFE with enqueue and grant each cycle
        while (stamp_ctr != 16'hFFFE) begin
            @(negedge clk);
            enq_valid = 1'b1; enq_bank = 3'd7; enq_row = 14'd0;
            enq_write = 1'b0; enq_low = 1'b0; issue_ready = 1'b1;
            @(posedge clk);
            #1;
            stamp_ctr = stamp_ctr + 1'b1;
        end
        @(negedge clk);
        enq_valid = 1'b0;
        @(negedge clk);
        issue_ready = 1'b0;
        #1;
        chk(grant_valid === 1'b0, "R7", int'(grant_valid), 0);

        enq(3'd7, 14'd0, 1'b0, 1'b0);   // slot 0, stamp 0xFFFE
        enq(3'd5, 14'd1, 1'b0, 1'b0);   // slot 1, stamp 0xFFFF
        issue(0, "R4");
        enq(3'd6, 14'd1, 1'b0, 1'b0);   // slot 0, stamp 0x0000
        issue(1, "R4");                  // 0xFFFF older than 0x0000
        issue(0, "R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule